// File: doc/BRIEF.md
# PLL Retune Sequencer

This block reprograms the control fields of an external frequency synthesizer when software or a power manager asks for a new operating point. A request gives the target oscillator rate in MHz, the parent clock in kHz, a pre-divider, and an integer and a fractional feedback divider. It is captured on a start strobe. The sequencer first checks that the request lies in the legal range and selects the loop-filter gains. It then takes one of two paths. If the synthesizer is locked and its integer divider and pre-divider already match the request, only the fractional field is rewritten. Otherwise it runs a full reprogramming pass and then waits for lock.

The full pass puts the synthesizer in reset and selects user mode. It clears the upper oscillator control word, sets the band bits, and writes the three divider fields and the gains. It then releases reset and polls the lock status at a fixed cycle interval, up to a fixed number of times. The fields are written one per cycle. Completion is marked by a one-cycle done pulse. Any failure raises an error flag that stays set until the next accepted request.

Top module: `pll_retune_seq`

## Requirements
- R1: After synchronous reset the reset pair is released, the mode field is 0, the upper control word holds all ones, the divider, gain and band fields are 0, and done and error are low.
- R2: A rate below 700 MHz or at or above 4000 MHz produces a done pulse with error set. No control field changes.
- R3: The reference is parent/pdiv rounded down, or parent×2 when pdiv is 0. A reference below 10000 kHz or at or above 125000 kHz produces a done pulse with error set.
- R4: The reference bands start at 10000, 12500, 15000, 20000, 25000, 50000, 75000 and 100000 kHz; call them bands 0 to 7. The proportional gain is taken from bands 0..7 of one of three rows. The row is {5,6,6,7,7,8,9,10} for a rate below 2200 MHz, {4,4,5,5,6,7,8,9} for a rate below 3100 MHz, and {4,5,5,6,7,8,9,10} otherwise.
- R5: The integral gain is 4 for a rate below 2200 MHz and 3 otherwise. The third gain is written as 0.
- R6: The low band bit is 1 exactly when the rate is below 1200 MHz. The high band bit is 1 exactly when the rate is at least 2200 MHz.
- R7: A full pass holds the reset pair asserted while the mode, upper word, band bits, dividers and gains are written. It leaves the mode at 7 and the upper word at 0, and releases reset at the end.
- R8: When lock is high and the requested integer divider and pre-divider equal the current ones, only the fractional field is written and reset is never asserted.
- R9: After reset release, lock is sampled once every POLL_CYC cycles. If it is still low at poll number MAX_POLLS (default 100), error is raised, about MAX_POLLS×POLL_CYC cycles after the start.
- R10: With rst_act_low_i at 1, the asserted reset pair is 2'b11 and the released pair is 2'b00. With rst_act_low_i at 0 the two values are swapped.
- R11: A start strobe that arrives while a request is in progress is ignored.
- R12: done pulses for exactly one cycle per request. Error stays set until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe |
| rst_act_low_i | input | 1 | Reset pair polarity select |
| lock_i | input | 1 | Synthesizer lock status |
| vco_mhz_i | input | 13 | Target oscillator rate, MHz |
| parent_khz_i | input | 20 | Parent clock, kHz |
| pdiv_i | input | 4 | Requested pre-divider |
| nint_i | input | 10 | Requested integer divider |
| nfrac_i | input | 20 | Requested fractional divider |
| pll_rst_o | output | 2 | Reset bit pair |
| mode_o | output | 3 | Mode select field |
| vco_upper_o | output | 32 | Upper oscillator control word |
| band_low_o | output | 1 | Low band bit |
| band_high_o | output | 1 | High band bit |
| nint_o | output | 10 | Integer divider field |
| nfrac_o | output | 20 | Fractional divider field |
| pdiv_o | output | 4 | Pre-divider field |
| kp_o | output | 4 | Proportional gain |
| ki_o | output | 3 | Integral gain |
| ka_o | output | 3 | Third gain |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Sticky error flag |

## Verification
The assertions run on every cycle. They check that done is a single-cycle pulse and that error clears when a start is accepted. They check that a busy start leaves the captured request untouched, and that the reset pair is held through every field write of a full pass and never asserted on the fractional path. They also check that valid requests always get a gain in range and that the poll counter stays within its limit. The actual gain values across all three rate rows and eight reference bands can only be shown by the bench's sweeps, which include references one count below each band edge and the doubled-reference case. The same holds for the band bits at their edges, the timeout distance in cycles, late lock, and the choice between the short and full paths when lock is missing.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

    parameter int RATE_W    = 13;
    parameter int PAR_W     = 20;
    parameter int PDIV_W    = 4;
    parameter int NINT_W    = 10;
    parameter int NFRAC_W   = 20;
    parameter int KP_W      = 4;
    parameter int KI_W      = 3;
    parameter int UPPER_W   = 32;
    parameter int REF_EDGES = 9;

    localparam int VCO_MIN_MHZ  = 700;
    localparam int VCO_LOWB_MHZ = 1200;
    localparam int VCO_HIGH_MHZ = 2200;
    localparam int VCO_HH_MHZ   = 3100;
    localparam int VCO_LIM_MHZ  = 4000;
    localparam logic [2:0] USER_MODE = 3'd7;

    // gain rows, band 0 in the lowest nibble
    localparam logic [31:0] KP_ROW_MID  = 32'hA987_7665;
    localparam logic [31:0] KP_ROW_HIGH = 32'h9876_5544;
    localparam logic [31:0] KP_ROW_HH   = 32'hA987_6554;

    typedef enum logic [1:0] {KPB_MID, KPB_HIGH, KPB_HH} kp_band_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_FRAC, S_RST, S_MODE, S_UPPER, S_BAND,
        S_NINT, S_NFRAC, S_PDIV, S_GAIN, S_REL, S_WAIT
    } seq_state_e;

    typedef struct packed {
        logic [RATE_W-1:0]  vco_mhz;
        logic [PAR_W-1:0]   parent_khz;
        logic [PDIV_W-1:0]  pdiv;
        logic [NINT_W-1:0]  nint;
        logic [NFRAC_W-1:0] nfrac;
    } req_t;

    typedef struct packed {
        logic            bad;
        logic [KP_W-1:0] kp;
        logic [KI_W-1:0] ki;
        logic            band_low;
        logic            band_high;
    } gain_t;

    // lower edge of each reference band in kHz; the last entry closes band 7
    function automatic int unsigned ref_edge_khz(input int idx);
        case (idx)
            0: return 10000;
            1: return 12500;
            2: return 15000;
            3: return 20000;
            4: return 25000;
            5: return 50000;
            6: return 75000;
            7: return 100000;
            default: return 125000;
        endcase
    endfunction

    function automatic logic [KP_W-1:0] kp_lookup(input kp_band_e band, input logic [2:0] idx);
        logic [31:0] row;
        case (band)
            KPB_MID:  row = KP_ROW_MID;
            KPB_HIGH: row = KP_ROW_HIGH;
            default:  row = KP_ROW_HH;
        endcase
        return row[idx*4 +: 4];
    endfunction

endpackage

// File: rtl/pll_gain_sel.sv
module pll_gain_sel
    import pll_retune_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] vco_mhz,
    input  logic [PAR_W-1:0]  parent_khz,
    input  logic [PDIV_W-1:0] pdiv,
    output gain_t             gain
);
    localparam int PROD_W = PAR_W + PDIV_W + 1;

    logic [REF_EDGES-1:0] ge;
    logic [PROD_W-1:0]    lhs;
    logic [2:0]           ref_idx;
    logic                 vco_bad, ref_bad;
    kp_band_e             band;

    // floor(p/d) >= T  <=>  p >= T*d, so no divider is needed
    assign lhs = (pdiv == '0) ? PROD_W'({parent_khz, 1'b0}) : PROD_W'(parent_khz);

    for (genvar g = 0; g < REF_EDGES; g++) begin : g_edge
        localparam logic [PROD_W-1:0] EDGE = PROD_W'(ref_edge_khz(g));
        logic [PROD_W-1:0] rhs;
        assign rhs   = (pdiv == '0) ? EDGE : PROD_W'(EDGE * PROD_W'(pdiv));
        assign ge[g] = (lhs >= rhs);
    end

    always_comb begin
        ref_idx = 3'($countones(ge[REF_EDGES-2:0]) - 1);
        ref_bad = !ge[0] || ge[REF_EDGES-1];
        vco_bad = (vco_mhz < RATE_W'(VCO_MIN_MHZ)) || (vco_mhz >= RATE_W'(VCO_LIM_MHZ));
        if (vco_mhz < RATE_W'(VCO_HIGH_MHZ))    band = KPB_MID;
        else if (vco_mhz < RATE_W'(VCO_HH_MHZ)) band = KPB_HIGH;
        else                                    band = KPB_HH;
        gain.bad       = vco_bad || ref_bad;
        gain.kp        = kp_lookup(band, ref_idx);
        gain.ki        = (band == KPB_MID) ? KI_W'(4) : KI_W'(3);
        gain.band_low  = (vco_mhz < RATE_W'(VCO_LOWB_MHZ));
        gain.band_high = (vco_mhz >= RATE_W'(VCO_HIGH_MHZ));
    end

    AST_KP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        !gain.bad |-> (gain.kp >= KP_W'(4) && gain.kp <= KP_W'(10))); // R4

endmodule

// File: rtl/pll_lock_wait.sv
module pll_lock_wait #(
    parameter int POLL_CYC  = 4,
    parameter int MAX_POLLS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic lock_i,
    output logic ok,
    output logic tmo
);
    localparam int TMR_W = $clog2(POLL_CYC + 1);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic             active;
    logic [TMR_W-1:0] timer;
    logic [CNT_W-1:0] polls;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            timer  <= '0;
            polls  <= '0;
            ok     <= 1'b0;
            tmo    <= 1'b0;
        end else begin
            ok  <= 1'b0;
            tmo <= 1'b0;
            if (go) begin
                active <= 1'b1;
                timer  <= '0;
                polls  <= '0;
            end else if (active) begin
                if (timer != '0) begin
                    timer <= timer - 1'b1;
                end else if (lock_i) begin
                    ok     <= 1'b1;
                    active <= 1'b0;
                end else if (polls == CNT_W'(MAX_POLLS - 1)) begin
                    tmo    <= 1'b1;
                    active <= 1'b0;
                end else begin
                    polls <= polls + 1'b1;
                    timer <= TMR_W'(POLL_CYC - 1);
                end
            end
        end
    end

    AST_POLLS_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        active |-> (polls < CNT_W'(MAX_POLLS))); // R9
    AST_OK_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ok && tmo)); // R9

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_retune_pkg::*;
#(
    parameter int                 POLL_CYC  = 4,
    parameter int                 MAX_POLLS = 100,
    parameter logic [UPPER_W-1:0] UPPER_RST = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               rst_act_low_i,
    input  logic               lock_i,
    input  logic [RATE_W-1:0]  vco_mhz_i,
    input  logic [PAR_W-1:0]   parent_khz_i,
    input  logic [PDIV_W-1:0]  pdiv_i,
    input  logic [NINT_W-1:0]  nint_i,
    input  logic [NFRAC_W-1:0] nfrac_i,
    output logic [1:0]         pll_rst_o,
    output logic [2:0]         mode_o,
    output logic [UPPER_W-1:0] vco_upper_o,
    output logic               band_low_o,
    output logic               band_high_o,
    output logic [NINT_W-1:0]  nint_o,
    output logic [NFRAC_W-1:0] nfrac_o,
    output logic [PDIV_W-1:0]  pdiv_o,
    output logic [KP_W-1:0]    kp_o,
    output logic [KI_W-1:0]    ki_o,
    output logic [KI_W-1:0]    ka_o,
    output logic               done_o,
    output logic               err_o
);
    seq_state_e state;
    req_t       req_q;
    gain_t      gain;
    logic       rst_hold_q;
    logic       lock_ok, lock_tmo;
    logic [1:0] rst_on;

    pll_gain_sel u_gain (
        .clk        (clk),
        .rst        (rst),
        .vco_mhz    (req_q.vco_mhz),
        .parent_khz (req_q.parent_khz),
        .pdiv       (req_q.pdiv),
        .gain       (gain)
    );

    pll_lock_wait #(.POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_wait (
        .clk    (clk),
        .rst    (rst),
        .go     (state == S_REL),
        .lock_i (lock_i),
        .ok     (lock_ok),
        .tmo    (lock_tmo)
    );

    assign rst_on    = rst_act_low_i ? 2'b11 : 2'b00;
    assign pll_rst_o = rst_hold_q ? rst_on : ~rst_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            req_q       <= '0;
            rst_hold_q  <= 1'b0;
            mode_o      <= '0;
            vco_upper_o <= UPPER_RST;
            band_low_o  <= 1'b0;
            band_high_o <= 1'b0;
            nint_o      <= '0;
            nfrac_o     <= '0;
            pdiv_o      <= '0;
            kp_o        <= '0;
            ki_o        <= '0;
            ka_o        <= '0;
            done_o      <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                S_IDLE: if (start_i) begin
                    req_q <= '{vco_mhz: vco_mhz_i, parent_khz: parent_khz_i,
                               pdiv: pdiv_i, nint: nint_i, nfrac: nfrac_i};
                    err_o <= 1'b0;
                    state <= S_CHECK;
                end
                S_CHECK: begin
                    if (gain.bad) begin
                        err_o  <= 1'b1;
                        done_o <= 1'b1;
                        state  <= S_IDLE;
                    end else if (lock_i && nint_o == req_q.nint && pdiv_o == req_q.pdiv) begin
                        state <= S_FRAC;
                    end else begin
                        state <= S_RST;
                    end
                end
                S_FRAC: begin
                    nfrac_o <= req_q.nfrac;
                    done_o  <= 1'b1;
                    state   <= S_IDLE;
                end
                S_RST:   begin rst_hold_q  <= 1'b1;        state <= S_MODE;  end
                S_MODE:  begin mode_o      <= USER_MODE;   state <= S_UPPER; end
                S_UPPER: begin vco_upper_o <= '0;          state <= S_BAND;  end
                S_BAND: begin
                    band_low_o  <= gain.band_low;
                    band_high_o <= gain.band_high;
                    state       <= S_NINT;
                end
                S_NINT:  begin nint_o  <= req_q.nint;  state <= S_NFRAC; end
                S_NFRAC: begin nfrac_o <= req_q.nfrac; state <= S_PDIV;  end
                S_PDIV:  begin pdiv_o  <= req_q.pdiv;  state <= S_GAIN;  end
                S_GAIN: begin
                    kp_o  <= gain.kp;
                    ki_o  <= gain.ki;
                    ka_o  <= '0;
                    state <= S_REL;
                end
                S_REL: begin rst_hold_q <= 1'b0; state <= S_WAIT; end
                S_WAIT: begin
                    if (lock_ok) begin
                        done_o <= 1'b1;
                        state  <= S_IDLE;
                    end else if (lock_tmo) begin
                        err_o  <= 1'b1;
                        done_o <= 1'b1;
                        state  <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R12
    AST_ERR_CLEARS_ON_START: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && start_i) |=> !err_o); // R12
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && start_i) |=> $stable(req_q)); // R11
    AST_WRITES_UNDER_RESET: assert property (@(posedge clk) disable iff (rst)
        (state inside {S_UPPER, S_BAND, S_NINT, S_NFRAC, S_PDIV, S_GAIN, S_REL})
        |-> (pll_rst_o == rst_on)); // R7
    AST_FRAC_NO_RESET: assert property (@(posedge clk) disable iff (rst)
        (state == S_FRAC) |=> (pll_rst_o == ~rst_on)); // R8

endmodule

// File: tb/test_pll_retune_seq.sv
`timescale 1ns/1ps
module test_pll_retune_seq;
    localparam int P = 4;
    localparam int NPOLL = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        act_low = 1'b0;
    logic        lock_i = 1'b0;
    logic [12:0] vco_mhz = '0;
    logic [19:0] parent_khz = '0;
    logic [3:0]  pdiv = '0;
    logic [9:0]  nint = '0;
    logic [19:0] nfrac = '0;
    logic [1:0]  pll_rst_o;
    logic [2:0]  mode_o;
    logic [31:0] vco_upper_o;
    logic        band_low_o, band_high_o;
    logic [9:0]  nint_o;
    logic [19:0] nfrac_o;
    logic [3:0]  pdiv_o;
    logic [3:0]  kp_o;
    logic [2:0]  ki_o, ka_o;
    logic        done_o, err_o;

    int tests = 0;
    int fails = 0;
    bit lock_en = 1'b1;
    int lock_dly = 5;
    int lcnt = 0;
    bit saw_rst = 1'b0;
    int elapsed = 0;

    int kp_tab [3][8] = '{'{5,6,6,7,7,8,9,10}, '{4,4,5,5,6,7,8,9}, '{4,5,5,6,7,8,9,10}};
    int edges [9] = '{10000,12500,15000,20000,25000,50000,75000,100000,125000};

    always #2 clk = ~clk;

    pll_retune_seq #(.POLL_CYC(P), .MAX_POLLS(NPOLL)) i_pll_retune_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .rst_act_low_i(act_low), .lock_i(lock_i),
        .vco_mhz_i(vco_mhz), .parent_khz_i(parent_khz), .pdiv_i(pdiv), .nint_i(nint),
        .nfrac_i(nfrac), .pll_rst_o(pll_rst_o), .mode_o(mode_o), .vco_upper_o(vco_upper_o),
        .band_low_o(band_low_o), .band_high_o(band_high_o), .nint_o(nint_o),
        .nfrac_o(nfrac_o), .pdiv_o(pdiv_o), .kp_o(kp_o), .ki_o(ki_o), .ka_o(ka_o),
        .done_o(done_o), .err_o(err_o)
    );

    function automatic logic [1:0] asserted_pair();
        return act_low ? 2'b11 : 2'b00;
    endfunction

    // synthesizer model: loses lock under reset, relocks lock_dly cycles after release
    always @(posedge clk) begin
        if (pll_rst_o == asserted_pair()) saw_rst = 1'b1;
        if (!lock_en || pll_rst_o == asserted_pair()) begin
            lock_i <= 1'b0;
            lcnt   <= 0;
        end else if (lcnt < lock_dly) begin
            lcnt <= lcnt + 1;
        end else begin
            lock_i <= 1'b1;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic launch(input int v, input int par, input int pd, input int ni, input int nf);
        @(negedge clk);
        vco_mhz = 13'(v); parent_khz = 20'(par); pdiv = 4'(pd);
        nint = 10'(ni); nfrac = 20'(nf);
        saw_rst = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        elapsed = 1;
        while (!done_o && elapsed < 2000) begin
            @(negedge clk);
            elapsed++;
        end
        chk("R12 done seen", done_o, 1);
        @(negedge clk);
        chk("R12 done one cycle", done_o, 0);
    endtask

    task automatic run(input int v, input int par, input int pd, input int ni, input int nf);
        launch(v, par, pd, ni, nf);
        wait_done();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset pair released", pll_rst_o, 2'b11);
        chk("R1 mode", mode_o, 0);
        chk("R1 upper word", vco_upper_o, 32'hFFFF_FFFF);
        chk("R1 nint", nint_o, 0);
        chk("R1 kp", kp_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 err", err_o, 0);
        repeat (10) @(negedge clk);

        // R7 full pass
        run(1500, 25000, 1, 40, 1234);
        chk("R7 reset asserted", saw_rst, 1);
        chk("R7 mode user", mode_o, 7);
        chk("R7 upper cleared", vco_upper_o, 0);
        chk("R7 reset released", pll_rst_o, 2'b11);
        chk("R7 nint", nint_o, 40);
        chk("R7 nfrac", nfrac_o, 1234);
        chk("R7 pdiv", pdiv_o, 1);
        chk("R7 err", err_o, 0);
        chk("R5 ka zero", ka_o, 0);

        // R8 fractional-only path
        repeat (10) @(negedge clk);
        run(1500, 25000, 1, 40, 777);
        chk("R8 no reset", saw_rst, 0);
        chk("R8 nfrac updated", nfrac_o, 777);
        chk("R8 short path", (elapsed < 8) ? 1 : 0, 1);
        chk("R8 err", err_o, 0);

        // R4 sweep: three rate rows x eight reference bands, on the edge and one below
        for (int vb = 0; vb < 3; vb++) begin
            for (int rb = 0; rb < 8; rb++) begin
                int v;
                int pd;
                int par;
                v = (vb == 0) ? 1000 : (vb == 1) ? 2500 : 3500;
                pd = (rb + vb) % 3;
                par = (pd == 0) ? edges[rb] / 2 : edges[rb] * pd;
                run(v, par, pd, 100 + vb * 16 + rb, rb);
                chk($sformatf("R4 kp row%0d band%0d", vb, rb), kp_o, kp_tab[vb][rb]);
                chk("R3 edge accepted", err_o, 0);
                if (rb > 0) begin
                    run(v, edges[rb] - 1, 1, 200 + vb * 16 + rb, rb);
                    chk($sformatf("R4 kp row%0d below band%0d", vb, rb), kp_o, kp_tab[vb][rb-1]);
                end
            end
        end

        // R5 / R6 boundaries
        run(700, 20000, 1, 301, 0);
        chk("R6 low at 700", band_low_o, 1);
        chk("R6 high at 700", band_high_o, 0);
        chk("R5 ki at 700", ki_o, 4);
        run(1199, 20000, 1, 302, 0);
        chk("R6 low at 1199", band_low_o, 1);
        run(1200, 20000, 1, 303, 0);
        chk("R6 low at 1200", band_low_o, 0);
        chk("R6 high at 1200", band_high_o, 0);
        run(2199, 20000, 1, 304, 0);
        chk("R6 high at 2199", band_high_o, 0);
        chk("R5 ki at 2199", ki_o, 4);
        chk("R4 kp at 2199", kp_o, 7);
        run(2200, 20000, 1, 305, 0);
        chk("R6 high at 2200", band_high_o, 1);
        chk("R5 ki at 2200", ki_o, 3);
        chk("R4 kp at 2200", kp_o, 5);
        run(3100, 20000, 1, 306, 0);
        chk("R4 kp at 3100", kp_o, 6);
        run(3999, 20000, 1, 307, 0);
        chk("R2 3999 valid", err_o, 0);
        chk("R5 ki at 3999", ki_o, 3);

        // R2 rate out of range
        run(699, 20000, 1, 400, 0);
        chk("R2 err below 700", err_o, 1);
        chk("R2 nint untouched", nint_o, 307);
        chk("R2 no reset", saw_rst, 0);
        repeat (10) @(negedge clk);
        chk("R12 err held", err_o, 1);
        run(4000, 20000, 1, 401, 0);
        chk("R2 err at 4000", err_o, 1);
        run(1500, 20000, 1, 402, 0);
        chk("R12 err cleared by next start", err_o, 0);

        // R3 reference out of range
        run(1500, 9999, 1, 410, 0);
        chk("R3 ref low", err_o, 1);
        run(1500, 125000, 1, 411, 0);
        chk("R3 ref at 125000", err_o, 1);
        run(1500, 4999, 0, 412, 0);
        chk("R3 doubled ref low", err_o, 1);
        run(1500, 250000, 2, 413, 0);
        chk("R3 divided ref at limit", err_o, 1);
        run(1500, 249999, 2, 414, 0);
        chk("R3 divided ref just inside", err_o, 0);
        chk("R4 kp band7 via divide", kp_o, 10);

        // R11 busy start ignored
        launch(1500, 20000, 1, 77, 5);
        repeat (3) @(negedge clk);
        nint = 10'd99;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk("R11 second start ignored", nint_o, 77);
        repeat (3) @(negedge clk);
        chk("R11 no second done", done_o, 0);

        // R10 polarity
        act_low = 1'b1;
        @(negedge clk);
        chk("R10 released pair active-low", pll_rst_o, 2'b00);
        repeat (10) @(negedge clk);
        run(1500, 20000, 1, 88, 3);
        chk("R10 assert pair 11 seen", saw_rst, 1);
        chk("R10 released after pass", pll_rst_o, 2'b00);
        chk("R10 err", err_o, 0);
        act_low = 1'b0;
        repeat (10) @(negedge clk);

        // R9 late lock, then timeout (same dividers while unlocked forces a full pass)
        lock_dly = 50 * P;
        run(1500, 20000, 1, 90, 0);
        chk("R9 late lock no err", err_o, 0);
        chk("R9 late lock waited", (elapsed > 40 * P) ? 1 : 0, 1);
        lock_dly = 5;
        lock_en = 1'b0;
        repeat (2) @(negedge clk);
        run(1500, 20000, 1, 90, 11);
        chk("R8 unlocked takes full pass", saw_rst, 1);
        chk("R9 timeout err", err_o, 1);
        chk("R9 timeout distance", (elapsed >= (NPOLL - 1) * P && elapsed <= (NPOLL - 1) * P + 20) ? 1 : 0, 1);
        lock_en = 1'b1;
        repeat (20) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule